// File: doc/BRIEF.md
# Fixed-Offset UDP Command Filter

This block watches a stream of received Ethernet frame bytes and picks out command packets addressed to it. Each byte arrives with a valid qualifier and optional start, end and error markers. Because the network is controlled (no IP options, no fragments, peers hold static address entries), every header field lives at a fixed byte offset. A byte index, cleared at the start of every frame, selects which constant each byte is compared with. Nothing is parsed and no checksum is verified.

When a frame passes every check and closes cleanly, the block issues a one-cycle register write. The UDP destination port becomes the register address, and the first four payload bytes become the 32-bit write data. Every other frame that closes is counted as dropped. A saturating match counter and a saturating drop counter are exposed as outputs.

Control is a four-state machine. `ST_IDLE` waits for a start marker. `ST_RECV` consumes frame bytes. `ST_COMMIT` is the write cycle. `ST_REJECT` is the drop cycle. The transitions are:
- From `ST_IDLE`, `ST_COMMIT` or `ST_REJECT`: a valid start byte moves to `ST_RECV`, or to `ST_REJECT` if the same byte also carries the end marker. Anything else returns to `ST_IDLE`.
- From `ST_RECV`: a valid end byte moves to `ST_COMMIT` when the frame is accepted and to `ST_REJECT` otherwise. Anything else stays in `ST_RECV`.

Top module: `udp_cmd_filter`

## Requirements
- R1: After reset, `wr_en` is low and both `match_count` and `drop_count` are zero.
- R2: An accepted frame raises `wr_en` for exactly one cycle, the cycle after its end byte is taken.
  - `wr_addr` carries frame bytes 36 (high) and 37 (low).
  - `wr_data` carries bytes 42..45, with byte 42 as the most significant.
  - `match_count` then rises by one.
- R3: Bytes 0..5 must equal `local_mac` (byte 0 = bits 47:40), or must all be 0xFF (broadcast). Otherwise the frame is dropped.
- R4: Bytes 12 and 13 must be 0x08 and 0x00, and byte 14 must be 0x45. Otherwise the frame is dropped.
- R5: Byte 23 must be 0x11 (UDP). Otherwise the frame is dropped.
- R6: Bytes 30..33 must equal `local_ip` (byte 30 = bits 31:24). Otherwise the frame is dropped.
- R7: A frame in which `in_err` is high on any of its bytes, including the end byte, is dropped.
- R8: A frame whose length is under 46 bytes is dropped. Longer frames are accepted; bytes past 45 are ignored, and so are the UDP checksum bytes 40..41.
- R9: Every frame that ends without being accepted raises `drop_count` by one and leaves `wr_en` low.
- R10: Bytes with `in_valid` high outside a frame are ignored, with no write and no count change. A start marker seen inside a frame marks that frame as bad, and the frame is dropped at its end.
- R11: Both counters saturate at all ones.
- R12: A new frame may start on the byte right after the previous end byte, and both frames are judged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error on this byte |
| in_data | input | 8 | Frame byte |
| local_mac | input | 48 | Own MAC address |
| local_ip | input | 32 | Own IPv4 address |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 16 | Register address (UDP destination port) |
| wr_data | output | 32 | Register write data |
| match_count | output | CNT_W | Accepted frames |
| drop_count | output | CNT_W | Dropped frames |

## Verification
A stale pass flag or a wrong byte index shows at the ports on the very frame that exposes it. The cycle after that frame's end byte carries a write that should not occur, or lacks one that should, and one cycle later the wrong counter moves. A mis-captured port or payload byte shows as a wrong `wr_addr` or `wr_data` during the write pulse itself. Each header field is therefore spoiled alone in its own frame, so a fault is pinned to a single offset. Back-to-back frames expose flags that fail to reset on a new start marker.

// File: rtl/udp_filt_pkg.sv
package udp_filt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_COMMIT,
        ST_REJECT
    } filt_state_t;

    // fixed byte offsets within the frame
    localparam int OFS_MAC     = 0;
    localparam int MAC_BYTES   = 6;
    localparam int OFS_ETYPE   = 12;
    localparam int OFS_VERLEN  = 14;
    localparam int OFS_PROTO   = 23;
    localparam int OFS_DST_IP  = 30;
    localparam int IP_BYTES    = 4;
    localparam int OFS_PORT    = 36;
    localparam int OFS_PAYLOAD = 42;
    localparam int DATA_BYTES  = 4;
    localparam int MIN_LEN     = OFS_PAYLOAD + DATA_BYTES;

    // expected constants
    localparam logic [7:0] ETYPE_HI  = 8'h08;
    localparam logic [7:0] ETYPE_LO  = 8'h00;
    localparam logic [7:0] VERLEN_V4 = 8'h45;
    localparam logic [7:0] PROTO_UDP = 8'h11;
    localparam logic [7:0] BCAST_B   = 8'hFF;

endpackage

// File: rtl/udp_byte_index.sv
module udp_byte_index #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             first,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] cnt_q;

    // index of the byte currently presented
    assign idx = first ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (idx == IDX_MAX) ? idx : idx + 1'b1;
        end
    end
endmodule

// File: rtl/udp_field_check.sv
module udp_field_check
    import udp_filt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             first,
    input  logic             bad_in,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    input  logic [47:0]      local_mac,
    input  logic [31:0]      local_ip,
    output logic             pass,
    output logic             err_now,
    output logic [15:0]      port,
    output logic [31:0]      payload
);
    localparam logic [IDX_W-1:0] I_ETYPE = IDX_W'(OFS_ETYPE);
    localparam logic [IDX_W-1:0] I_ETLO  = IDX_W'(OFS_ETYPE + 1);
    localparam logic [IDX_W-1:0] I_VER   = IDX_W'(OFS_VERLEN);
    localparam logic [IDX_W-1:0] I_PROTO = IDX_W'(OFS_PROTO);
    localparam logic [IDX_W-1:0] I_PORT  = IDX_W'(OFS_PORT);
    localparam logic [IDX_W-1:0] I_PORTL = IDX_W'(OFS_PORT + 1);
    localparam logic [IDX_W-1:0] I_PAY   = IDX_W'(OFS_PAYLOAD);
    localparam logic [IDX_W-1:0] I_PAYE  = IDX_W'(OFS_PAYLOAD + DATA_BYTES - 1);

    logic uc_q, bc_q, hdr_q, err_q;
    logic [15:0] port_q;
    logic [31:0] pay_q;

    logic base_uc, base_bc, base_hdr, base_err;
    logic in_mac, in_ip, mac_hit, ip_hit, hdr_hit;

    assign base_uc  = first ? 1'b1 : uc_q;
    assign base_bc  = first ? 1'b1 : bc_q;
    assign base_hdr = first ? 1'b1 : hdr_q;
    assign base_err = first ? 1'b0 : err_q;

    // address byte compares, one slot per position
    always_comb begin
        in_mac  = 1'b0;
        mac_hit = 1'b0;
        for (int k = 0; k < MAC_BYTES; k++) begin
            if (idx == IDX_W'(OFS_MAC + k)) begin
                in_mac  = 1'b1;
                mac_hit = (byte_in == local_mac[8*(MAC_BYTES-1-k) +: 8]);
            end
        end
    end

    always_comb begin
        in_ip  = 1'b0;
        ip_hit = 1'b0;
        for (int k = 0; k < IP_BYTES; k++) begin
            if (idx == IDX_W'(OFS_DST_IP + k)) begin
                in_ip  = 1'b1;
                ip_hit = (byte_in == local_ip[8*(IP_BYTES-1-k) +: 8]);
            end
        end
    end

    always_comb begin
        unique case (idx)
            I_ETYPE: hdr_hit = (byte_in == ETYPE_HI);
            I_ETLO:  hdr_hit = (byte_in == ETYPE_LO);
            I_VER:   hdr_hit = (byte_in == VERLEN_V4);
            I_PROTO: hdr_hit = (byte_in == PROTO_UDP);
            default: hdr_hit = in_ip ? ip_hit : 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uc_q   <= 1'b0;
            bc_q   <= 1'b0;
            hdr_q  <= 1'b0;
            err_q  <= 1'b0;
            port_q <= '0;
            pay_q  <= '0;
        end else if (step) begin
            uc_q  <= base_uc & (~in_mac | mac_hit);
            bc_q  <= base_bc & (~in_mac | (byte_in == BCAST_B));
            hdr_q <= base_hdr & hdr_hit;
            err_q <= base_err | bad_in;
            if (idx == I_PORT)  port_q[15:8] <= byte_in;
            if (idx == I_PORTL) port_q[7:0]  <= byte_in;
            if (idx >= I_PAY && idx <= I_PAYE) pay_q <= {pay_q[23:0], byte_in};
        end
    end

    assign pass    = (uc_q | bc_q) & hdr_q;
    assign err_now = base_err | bad_in;
    assign port    = port_q;
    assign payload = pay_q;
endmodule

// File: rtl/udp_frame_fsm.sv
module udp_frame_fsm
    import udp_filt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             pass,
    input  logic             err_now,
    input  logic [IDX_W-1:0] idx,
    output logic             in_frame,
    output logic             step,
    output logic             first,
    output logic             commit,
    output logic             reject
);
    localparam logic [IDX_W-1:0] I_LAST = IDX_W'(MIN_LEN - 1);

    filt_state_t state_q, state_nx;
    logic accept;

    assign accept = pass & ~err_now & (idx >= I_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RECV: begin
                if (in_valid && in_eof) state_nx = accept ? ST_COMMIT : ST_REJECT;
            end
            ST_IDLE, ST_COMMIT, ST_REJECT: begin
                if (in_valid && in_sof) state_nx = in_eof ? ST_REJECT : ST_RECV;
                else                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_frame = (state_q == ST_RECV);
        first    = in_sof & ~in_frame;
        step     = in_valid & (first | in_frame);
        commit   = (state_q == ST_COMMIT);
        reject   = (state_q == ST_REJECT);
    end
endmodule

// File: rtl/udp_event_count.sv
module udp_event_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                       value <= '0;
        else if (inc && value != CNT_MAX) value <= value + 1'b1;
    end
endmodule

// File: rtl/udp_cmd_filter.sv
module udp_cmd_filter
    import udp_filt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_err,
    input  logic [7:0]       in_data,
    input  logic [47:0]      local_mac,
    input  logic [31:0]      local_ip,
    output logic             wr_en,
    output logic [15:0]      wr_addr,
    output logic [31:0]      wr_data,
    output logic [CNT_W-1:0] match_count,
    output logic [CNT_W-1:0] drop_count
);
    localparam int IDX_W  = $clog2(MIN_LEN + 1);
    localparam int N_EVT  = 2;

    logic             in_frame, step, first, commit, reject;
    logic             pass, err_now, bad_byte;
    logic [IDX_W-1:0] idx;
    logic [N_EVT-1:0] ev_inc;
    logic [CNT_W-1:0] ev_val [N_EVT];

    // a start marker inside a running frame spoils that frame
    assign bad_byte = in_err | (in_sof & in_frame);

    udp_byte_index #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .step(step), .first(first), .idx(idx)
    );

    udp_field_check #(.IDX_W(IDX_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .step(step), .first(first),
        .bad_in(bad_byte), .idx(idx), .byte_in(in_data),
        .local_mac(local_mac), .local_ip(local_ip),
        .pass(pass), .err_now(err_now), .port(wr_addr), .payload(wr_data)
    );

    udp_frame_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .pass(pass), .err_now(err_now), .idx(idx),
        .in_frame(in_frame), .step(step), .first(first),
        .commit(commit), .reject(reject)
    );

    assign ev_inc = {reject, commit};

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        udp_event_count #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(ev_inc[g]), .value(ev_val[g])
        );
    end

    assign wr_en       = commit;
    assign match_count = ev_val[0];
    assign drop_count  = ev_val[1];
endmodule

// File: rtl/udp_cmd_filter_chk.sv
module udp_cmd_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             in_err,
    input logic             wr_en,
    input logic [CNT_W-1:0] match_count,
    input logic [CNT_W-1:0] drop_count
);
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R2
    AST_WR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid && in_eof)); // R2
    AST_WR_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(in_err)); // R7
    AST_MATCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && match_count != '1) |=> match_count == $past(match_count) + 1'b1); // R2
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(match_count)); // R9
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(drop_count)); // R9
    AST_MATCH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        match_count == '1 |=> match_count == '1); // R11
    AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count == '1 |=> drop_count == '1); // R11
endmodule

bind udp_cmd_filter udp_cmd_filter_chk #(.CNT_W(CNT_W)) u_prop (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
    .in_err(in_err), .wr_en(wr_en), .match_count(match_count),
    .drop_count(drop_count)
);

// File: tb/udp_cmd_filter_test.sv
module udp_cmd_filter_test;
    localparam int CW = 4;
    localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;
    localparam logic [31:0] MY_IP  = 32'hC0_A8_0A_07;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
    logic [7:0] in_data = '0;
    logic wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [CW-1:0] match_count, drop_count;

    int checks = 0, errors = 0;
    int exp_match = 0, exp_drop = 0;
    logic [7:0] fbuf [0:79];
    logic got_wr;
    logic [15:0] got_addr;
    logic [31:0] got_data;

    always #5 clk = ~clk;

    udp_cmd_filter #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
        .local_mac(MY_MAC), .local_ip(MY_IP), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .match_count(match_count), .drop_count(drop_count)
    );

    function automatic int sat(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [15:0] port, input logic [31:0] data);
        for (int i = 0; i < 80; i++) fbuf[i] = 8'hA5;
        for (int i = 0; i < 6; i++) fbuf[i] = MY_MAC[8*(5-i) +: 8];
        for (int i = 6; i < 12; i++) fbuf[i] = 8'h30 + 8'(i);
        fbuf[12] = 8'h08; fbuf[13] = 8'h00; fbuf[14] = 8'h45; fbuf[15] = 8'h00;
        fbuf[23] = 8'h11; fbuf[24] = 8'h9C; fbuf[25] = 8'h3E;
        for (int i = 0; i < 4; i++) fbuf[26+i] = 8'h0A + 8'(i);
        for (int i = 0; i < 4; i++) fbuf[30+i] = MY_IP[8*(3-i) +: 8];
        fbuf[34] = 8'hC0; fbuf[35] = 8'h01;
        fbuf[36] = port[15:8]; fbuf[37] = port[7:0];
        fbuf[38] = 8'h00; fbuf[39] = 8'h0C;
        fbuf[40] = 8'hDE; fbuf[41] = 8'hAD;
        for (int i = 0; i < 4; i++) fbuf[42+i] = data[8*(3-i) +: 8];
    endtask

    task automatic send(input int len, input int err_at, input int sof2_at);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0) || (i == sof2_at);
            in_eof   = (i == len - 1);
            in_err   = (i == err_at);
            in_data  = fbuf[i];
            @(negedge clk);
        end
        got_wr = wr_en; got_addr = wr_addr; got_data = wr_data;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    endtask

    task automatic judge(input string tag, input bit ok, input logic [15:0] port,
                         input logic [31:0] data);
        check({tag, " wr_en"}, 32'(got_wr), 32'(ok));
        if (ok) begin
            check({tag, " wr_addr"}, 32'(got_addr), 32'(port));
            check({tag, " wr_data"}, got_data, data);
            exp_match = sat(exp_match + 1);
        end else begin
            exp_drop = sat(exp_drop + 1);
        end
    endtask

    task automatic counters(input string tag);
        repeat (2) @(negedge clk);
        check({tag, " match_count"}, 32'(match_count), 32'(exp_match));
        check({tag, " drop_count"}, 32'(drop_count), 32'(exp_drop));
    endtask

    task automatic t_reset;
        check("R1 wr_en", 32'(wr_en), 32'd0);
        check("R1 match_count", 32'(match_count), 32'd0);
        check("R1 drop_count", 32'(drop_count), 32'd0);
    endtask

    task automatic t_good;
        build(16'h0123, 32'hCAFE_F00D);
        send(46, -1, -1); judge("R2 minimal", 1, 16'h0123, 32'hCAFE_F00D); counters("R2");
        build(16'hFFFE, 32'h0102_0304);
        send(64, -1, -1); judge("R8 long frame", 1, 16'hFFFE, 32'h0102_0304); counters("R8");
    endtask

    task automatic t_mac;
        build(16'h0010, 32'h1111_2222);
        for (int i = 0; i < 6; i++) fbuf[i] = 8'hFF;
        send(46, -1, -1); judge("R3 broadcast", 1, 16'h0010, 32'h1111_2222); counters("R3");
        build(16'h0011, 32'h3333_4444);
        fbuf[5] = 8'h56;
        send(46, -1, -1); judge("R3 foreign mac", 0, 0, 0); counters("R3");
        build(16'h0011, 32'h3333_4444);
        fbuf[0] = 8'hFF; fbuf[1] = 8'hFF;
        send(46, -1, -1); judge("R3 mixed mac", 0, 0, 0); counters("R3");
    endtask

    task automatic t_header;
        build(16'h0020, 32'h5);
        fbuf[12] = 8'h86;
        send(46, -1, -1); judge("R4 ethertype", 0, 0, 0);
        build(16'h0020, 32'h5);
        fbuf[14] = 8'h46;
        send(46, -1, -1); judge("R4 ip options", 0, 0, 0);
        build(16'h0020, 32'h5);
        fbuf[23] = 8'h06;
        send(46, -1, -1); judge("R5 protocol", 0, 0, 0);
        build(16'h0020, 32'h5);
        fbuf[33] = 8'h08;
        send(46, -1, -1); judge("R6 dest ip", 0, 0, 0);
        counters("R9 header drops");
    endtask

    task automatic t_err_short;
        build(16'h0030, 32'h6);
        send(46, 20, -1); judge("R7 error mid", 0, 0, 0);
        build(16'h0030, 32'h6);
        send(46, 45, -1); judge("R7 error last", 0, 0, 0);
        build(16'h0030, 32'h6);
        send(45, -1, -1); judge("R8 short", 0, 0, 0);
        counters("R9 error drops");
    endtask

    task automatic t_stray;
        build(16'h0040, 32'h7);
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b1; in_eof = (i == 9); in_data = fbuf[i];
            @(negedge clk);
            check("R10 stray byte wr_en", 32'(wr_en), 32'd0);
        end
        in_valid = 1'b0; in_eof = 1'b0;
        counters("R10 stray");
        send(46, -1, 10); judge("R10 inner start", 0, 0, 0); counters("R10");
    endtask

    task automatic t_b2b;
        build(16'h0A0B, 32'hAABB_CCDD);
        send(46, -1, -1); judge("R12 first", 1, 16'h0A0B, 32'hAABB_CCDD);
        fbuf[23] = 8'h01;
        send(46, -1, -1); judge("R12 second bad", 0, 0, 0);
        build(16'h0C0D, 32'h1234_5678);
        send(46, -1, -1); judge("R12 third", 1, 16'h0C0D, 32'h1234_5678);
        counters("R12");
    endtask

    task automatic t_sat;
        build(16'h0050, 32'h8);
        for (int n = 0; n < 14; n++) send(46, -1, -1);
        for (int n = 0; n < 14; n++) exp_match = sat(exp_match + 1);
        for (int n = 0; n < 14; n++) send(30, -1, -1);
        for (int n = 0; n < 14; n++) exp_drop = sat(exp_drop + 1);
        counters("R11 saturate");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_mac();
        t_header();
        t_err_short();
        t_stray();
        t_b2b();
        t_sat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule